// File: doc/BRIEF.md
# Multi-channel conversion sequencer with completion flag

This block sits between a simple register bus and an analog-to-digital converter. Software writes one 16-bit control word to choose an operating mode and the highest channel to convert, then sets the run bit. The sequencer sends the converter one channel number at a time, together with a one-cycle request strobe. It waits for the converter's done strobe and stores the returned sample in a result register that belongs to that channel. When the work set by the mode is finished, it raises a completion flag. The completion flag, gated by an enable bit, forms the interrupt line.

There are three working modes. Single converts one channel. Multi makes one ascending pass over channels 0 up to the highest channel. Scan repeats that pass until something stops it. The completion flag is deliberately hard to clear by accident. A zero write clears it only after software has read the control word while the flag was set. A DMA read of any result register also clears it. A standby request, or a zero written to the run bit, drops any conversion in flight.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word and every result register read 0. The interrupt is low and no request strobe is issued.
- R2: Address 0 is the control word. Address c+1 returns the result of channel c, zero-extended. Addresses beyond the last channel read 0. The control word layout is: bit 15 completion flag, bit 14 interrupt enable, bit 13 run, bits [4:3] mode (00 single, 01 multi, 10 scan, 11 behaves as single), bits [2:0] highest channel. Bits 12 to 5 always read 0, and writes to them have no effect.
- R3: A write that sets run while idle raises `conv_req` for exactly one cycle, in the second cycle after the write edge. `conv_chan` stays stable from the request until the next request.
- R4: In single mode (or mode 11), only the channel named in bits [2:0] is converted, and no other result register changes. On its done strobe, the flag sets and run clears.
- R5: In multi mode, channels 0 up to the highest channel are converted once, in ascending order. After the last one, the flag sets and run clears.
- R6: In scan mode, passes repeat from channel 0. The flag sets at the end of each pass, and run stays 1.
- R7: A zero written to bit 15 clears the flag only if the control word was read while the flag was 1 since the flag last set. Without that read, the flag stays set.
- R8: A read of a result address with `dma_ack` high clears the flag.
- R9: If a pass ends in the same cycle as a qualifying clear, the flag ends up set.
- R10: `irq` is high exactly when both the flag and the interrupt enable are 1.
- R11: Writing 0 to run during a conversion abandons it and returns to idle. A done strobe after that changes no result register and does not set the flag.
- R12: `standby` clears run and aborts like R11. A write that sets run while `standby` is high is ignored.
- R13: While run is 1, writes leave the mode and highest-channel fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| dma_ack | input | 1 | Marks the current read as a DMA transfer |
| standby | input | 1 | Stop request; clears run |
| conv_req | output | 1 | One-cycle conversion request strobe |
| conv_chan | output | 3 | Channel for the current request |
| conv_done | input | 1 | Converter finished the current request |
| conv_data | input | 12 | Sample returned with `conv_done` |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets the clearing rules. A design that clears the flag on any zero write fails the blind-write case. A design that lets the clear win over a pass end that arrives in the same cycle loses a completion. A design that ignores the DMA path leaves the interrupt stuck high. The bench also stops conversions with the run bit and with standby while a request is outstanding, and then returns a late done strobe. A sequencer that still accepts it overwrites a result register. The bench checks the ascending channel order, the scan wrap back to channel 0, and the single-mode channel choice. It also checks that mode writes during a run are rejected. A wrong order, a missed wrap, or a corrupted configuration shows up as a mismatched channel or readback.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Operating modes held in the control word
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_MULTI  = 2'b01,
    MODE_SCAN   = 2'b10,
    MODE_ALT    = 2'b11
  } conv_mode_e;

  // Sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_REQ  = 2'b01,
    SQ_WAIT = 2'b10
  } seq_state_e;

  // Control word bit positions that software decodes
  localparam int FLAG_BIT  = 15;
  localparam int IE_BIT    = 14;
  localparam int START_BIT = 13;

endpackage

// File: rtl/adc_csr.sv
module adc_csr
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctl,
  input  logic            rd_ctl,
  input  logic [15:0]     wdata,
  input  logic            dma_clr,
  input  logic            standby,
  input  logic            pass_end,
  input  logic            stop_auto,
  output logic            flag_o,
  output logic            ie_o,
  output logic            start_o,
  output logic            seen_o,
  output conv_mode_e      mode_o,
  output logic [CH_W-1:0] top_o,
  output logic [15:0]     rdata_o
);

  localparam int MODE_LO = CH_W;
  localparam int MODE_HI = CH_W + 1;

  logic            flag_q, flag_d;
  logic            seen_q, seen_d;
  logic            ie_q, ie_d;
  logic            start_q, start_d;
  conv_mode_e      mode_q, mode_d;
  logic [CH_W-1:0] top_q, top_d;
  logic            zero_wr, flag_clr, cfg_we;

  // Next-state logic
  always_comb begin
    zero_wr  = wr_ctl && !wdata[FLAG_BIT];
    flag_clr = (zero_wr && seen_q) || dma_clr;

    // a pass ending in this cycle outranks any clear
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (pass_end) flag_d = 1'b1;

    // observation latch: armed by a read that sees the flag set
    seen_d = seen_q;
    if (rd_ctl && flag_q) seen_d = 1'b1;
    else if (zero_wr)     seen_d = 1'b0;
    if (!flag_d)          seen_d = 1'b0;

    ie_d = wr_ctl ? wdata[IE_BIT] : ie_q;

    start_d = start_q;
    if (wr_ctl && wdata[START_BIT] && !standby) start_d = 1'b1;
    if (stop_auto)                              start_d = 1'b0;
    if (wr_ctl && !wdata[START_BIT])            start_d = 1'b0;
    if (standby)                                start_d = 1'b0;

    // configuration is frozen while a run is active
    cfg_we = wr_ctl && !start_q;
    mode_d = conv_mode_e'(wdata[MODE_HI:MODE_LO]);
    top_d  = wdata[CH_W-1:0];
  end

  // Status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      seen_q  <= 1'b0;
      ie_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      seen_q  <= seen_d;
      ie_q    <= ie_d;
      start_q <= start_d;
    end
  end

  // Configuration registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SINGLE;
      top_q  <= '0;
    end else if (cfg_we) begin
      mode_q <= mode_d;
      top_q  <= top_d;
    end
  end

  // Readback; unlisted bits, reserved bit 12 included, read zero
  always_comb begin
    rdata_o                   = '0;
    rdata_o[FLAG_BIT]         = flag_q;
    rdata_o[IE_BIT]           = ie_q;
    rdata_o[START_BIT]        = start_q;
    rdata_o[MODE_HI:MODE_LO]  = mode_q;
    rdata_o[CH_W-1:0]         = top_q;
  end

  assign flag_o  = flag_q;
  assign ie_o    = ie_q;
  assign start_o = start_q;
  assign seen_o  = seen_q;
  assign mode_o  = mode_q;
  assign top_o   = top_q;

endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  conv_mode_e      mode,
  input  logic [CH_W-1:0] top,
  input  logic            conv_done,
  output logic            conv_req,
  output logic [CH_W-1:0] conv_chan,
  output logic            res_we,
  output logic [CH_W-1:0] res_idx,
  output logic            pass_end,
  output logic            stop_auto
);

  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] cur_q, cur_d;
  logic            one_chan, last, accept;

  always_comb begin
    one_chan  = (mode == MODE_SINGLE) || (mode == MODE_ALT);
    last      = one_chan || (cur_q == top);
    // a done strobe counts only while the run bit is still set
    accept    = (state_q == SQ_WAIT) && run && conv_done;
    pass_end  = accept && last;
    stop_auto = pass_end && (mode != MODE_SCAN);

    state_d = state_q;
    cur_d   = cur_q;
    if (!run) begin
      state_d = SQ_IDLE;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          state_d = SQ_REQ;
          cur_d   = one_chan ? top : '0;
        end
        SQ_REQ:  state_d = SQ_WAIT;
        SQ_WAIT: begin
          if (conv_done) begin
            if (!last) begin
              state_d = SQ_REQ;
              cur_d   = cur_q + CH_W'(1);
            end else if (mode == MODE_SCAN) begin
              state_d = SQ_REQ;
              cur_d   = '0;
            end else begin
              state_d = SQ_IDLE;
            end
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
    end
  end

  assign conv_req  = (state_q == SQ_REQ) && run;
  assign conv_chan = cur_q;
  assign res_we    = accept;
  assign res_idx   = cur_q;

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int N_CH   = 8,
  parameter int CH_W   = 3,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CH_W-1:0]   idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CH_W-1:0]   rd_idx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] vals [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [DATA_W-1:0] val_q;
    logic              hit;
    assign hit = we && (idx == CH_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= wdata;
    end
    assign vals[c] = val_q;
  end

  assign rdata = (int'(rd_idx) < N_CH) ? vals[rd_idx] : '0;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [15:0]               bus_wdata,
  output logic [15:0]               bus_rdata,
  input  logic                      dma_ack,
  input  logic                      standby,
  output logic                      conv_req,
  output logic [$clog2(N_CH)-1:0]   conv_chan,
  input  logic                      conv_done,
  input  logic [DATA_W-1:0]         conv_data,
  output logic                      irq
);

  localparam int CH_W = $clog2(N_CH);

  // reset: asserts at once, releases after two clock edges
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // address decode
  logic            ctl_sel, res_hit, wr_ctl, rd_ctl, dma_clr;
  logic [CH_W-1:0] res_sel;
  always_comb begin
    ctl_sel = (bus_addr == '0);
    res_hit = !ctl_sel && (int'(bus_addr) <= N_CH);
    res_sel = CH_W'(bus_addr - ADDR_W'(1));
    wr_ctl  = bus_wr && ctl_sel;
    rd_ctl  = bus_rd && ctl_sel;
    dma_clr = dma_ack && bus_rd && res_hit;
  end

  logic              flag_w, ie_w, start_w, seen_w, pass_end, stop_auto, res_we;
  conv_mode_e        mode_w;
  logic [CH_W-1:0]   top_w, res_idx;
  logic [15:0]       ctl_rdata;
  logic [DATA_W-1:0] res_rdata;

  adc_csr #(.CH_W(CH_W)) u_csr (
    .clk(clk), .rst_n(rst_core_n), .wr_ctl(wr_ctl), .rd_ctl(rd_ctl),
    .wdata(bus_wdata), .dma_clr(dma_clr), .standby(standby),
    .pass_end(pass_end), .stop_auto(stop_auto), .flag_o(flag_w), .ie_o(ie_w),
    .start_o(start_w), .seen_o(seen_w), .mode_o(mode_w), .top_o(top_w),
    .rdata_o(ctl_rdata)
  );

  adc_sequencer #(.CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .run(start_w), .mode(mode_w), .top(top_w),
    .conv_done(conv_done), .conv_req(conv_req), .conv_chan(conv_chan),
    .res_we(res_we), .res_idx(res_idx), .pass_end(pass_end),
    .stop_auto(stop_auto)
  );

  adc_result_bank #(.N_CH(N_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .we(res_we), .idx(res_idx),
    .wdata(conv_data), .rd_idx(res_sel), .rdata(res_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (ctl_sel)      bus_rdata = ctl_rdata;
    else if (res_hit) bus_rdata[DATA_W-1:0] = res_rdata;
  end

  assign irq = flag_w && ie_w;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              dma_ack,
  input logic              standby,
  input logic              conv_req,
  input logic [CH_W-1:0]   conv_chan,
  input logic              conv_done,
  input logic              flag,
  input logic              seen,
  input logic              start
);

  localparam int RSV_LO = CH_W + 2;

  // R2: unused control bits read zero
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == '0) |-> (bus_rdata[12:RSV_LO] == '0));

  // R3: request is a single-cycle strobe
  p_req_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  // R3: channel holds after its request
  p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> $stable(conv_chan));

  // R4, R5, R6: the flag only rises after a done strobe
  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(conv_done));

  // R7: a zero write without a prior observing read keeps the flag
  p_blind_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && !bus_wdata[15] && flag && !seen && !dma_ack)
      |=> flag);

  // R12: standby stops the run and suppresses requests
  p_standby_r12: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!start && !conv_req));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .dma_ack(dma_ack), .standby(standby), .conv_req(conv_req),
  .conv_chan(conv_chan), .conv_done(conv_done), .flag(flag_w),
  .seen(seen_w), .start(start_w)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, dma_ack = 1'b0, standby = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        conv_req, conv_done = 1'b0, irq;
  logic [2:0]  conv_chan;
  logic [11:0] conv_data = '0;

  always #10 clk = ~clk;  // 50 MHz

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_ack(dma_ack), .standby(standby), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0, seqn = 0;
  bit live = 0;
  int exp_res [8];
  bit pend = 0;
  int pend_ch = 0;

  // ---- behavioural reference model ----
  int m_flag, m_seen, m_ie, m_start, m_mode, m_top, m_state, m_cur;
  int m_res [8];

  function automatic int model_read(int a);
    if (a == 0)
      return (m_flag << 15) | (m_ie << 14) | (m_start << 13) | (m_mode << 3) | m_top;
    if (a >= 1 && a <= 8) return m_res[a-1];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_seen = 0; m_ie = 0; m_start = 0; m_mode = 0; m_top = 0;
      m_state = 0; m_cur = 0;
      for (int i = 0; i < 8; i++) m_res[i] = 0;
    end else begin
      int a, wc, rc, zw, dmac, acc, lst, pe, sa, one, fn, sn, stn, nst, ncur;
      a    = int'(bus_addr);
      wc   = (bus_wr && a == 0);
      rc   = (bus_rd && a == 0);
      zw   = wc && !bus_wdata[15];
      dmac = dma_ack && bus_rd && a >= 1 && a <= 8;
      one  = (m_mode == 0 || m_mode == 3);
      acc  = (m_state == 2 && m_start && conv_done);
      lst  = one || (m_cur == m_top);
      pe   = acc && lst;
      sa   = pe && (m_mode != 2);
      if (acc) m_res[m_cur] = int'(conv_data);
      fn = m_flag;
      if ((zw && m_seen) || dmac) fn = 0;
      if (pe) fn = 1;
      sn = m_seen;
      if (rc && m_flag) sn = 1; else if (zw) sn = 0;
      if (!fn) sn = 0;
      stn = m_start;
      if (wc && bus_wdata[13] && !standby) stn = 1;
      if (sa) stn = 0;
      if (wc && !bus_wdata[13]) stn = 0;
      if (standby) stn = 0;
      nst = m_state; ncur = m_cur;
      if (!m_start) nst = 0;
      else if (m_state == 0) begin nst = 1; ncur = one ? m_top : 0; end
      else if (m_state == 1) nst = 2;
      else if (conv_done) begin
        if (!lst) begin nst = 1; ncur = m_cur + 1; end
        else if (m_mode == 2) begin nst = 1; ncur = 0; end
        else nst = 0;
      end
      if (wc && !m_start) begin m_mode = int'(bus_wdata[4:3]); m_top = int'(bus_wdata[2:0]); end
      if (wc) m_ie = bus_wdata[14];
      m_flag = fn; m_seen = sn; m_start = stn; m_state = nst; m_cur = ncur;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk("R10 irq vs model", int'(irq), (m_flag && m_ie) ? 1 : 0);
      chk("R3 conv_req vs model", int'(conv_req), (m_state == 1 && m_start) ? 1 : 0);
      if (conv_req) chk("R3 conv_chan vs model", int'(conv_chan), m_cur);
      if (bus_rd) chk("R2 readback vs model", int'(bus_rdata), model_read(int'(bus_addr)));
    end
    if (conv_req === 1'b1) begin pend = 1; pend_ch = int'(conv_chan); end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = d; tick(); bus_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    bus_rd = 1; bus_addr = 4'(a); #1 v = int'(bus_rdata); tick(); bus_rd = 0;
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    int v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wait_req(output int ch);
    int n = 0;
    while (!pend && n < 200) begin tick(); n++; end
    if (!pend) chk("R3 request timeout", 0, 1);
    ch = pend_ch; pend = 0;
  endtask

  task automatic mk_data(input int ch, output int d);
    seqn++;
    d = (ch * 291 + seqn * 17 + 5) & 'hFFF;
  endtask

  task automatic serve(input int lat, output int ch);
    int d;
    wait_req(ch);
    repeat (lat) tick();
    mk_data(ch, d);
    conv_done = 1; conv_data = 12'(d); tick(); conv_done = 0;
    exp_res[ch] = d;
  endtask

  initial begin
    int ch, d, old;
    for (int i = 0; i < 8; i++) exp_res[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) tick();
    live = 1;

    // R1 reset state
    rd_chk("R1 control after reset", 0, 0);
    rd_chk("R1 result after reset", 1, 0);
    rd_chk("R2 unmapped address", 9, 0);
    rd_chk("R2 unmapped address top", 15, 0);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 no request after reset", int'(conv_req), 0);

    // R2 reserved and unused bits ignored
    wr(0, 16'h1FEA);
    rd_chk("R2 reserved bits read zero", 0, 'h000A);

    // R3/R4 single mode, channel 5, interrupt enabled
    pend = 0;
    wr(0, 16'h6005);
    chk("R3 no request in first cycle", int'(conv_req), 0);
    tick();
    chk("R3 request in second cycle", int'(conv_req), 1);
    serve(2, ch);
    chk("R4 single channel choice", ch, 5);
    tick();
    chk("R10 irq with flag and enable", int'(irq), 1);
    rd_chk("R4 result of chosen channel", 6, exp_res[5]);
    rd_chk("R4 other channel untouched", 1, 0);
    // R7 blind zero write leaves the flag
    wr(0, 16'h4005);
    chk("R7 blind zero write keeps irq", int'(irq), 1);
    rd_chk("R7 flag still set, run cleared", 0, 'hC005);
    wr(0, 16'h4005);
    rd_chk("R7 flag cleared after read", 0, 'h4005);
    chk("R10 irq low after clear", int'(irq), 0);

    // R5 multi mode over channels 0..3
    pend = 0;
    wr(0, 16'h600B);
    for (int i = 0; i < 4; i++) begin
      serve(1 + (i % 2), ch);
      chk("R5 ascending channel", ch, i);
    end
    tick();
    chk("R10 irq after multi pass", int'(irq), 1);
    for (int i = 0; i < 4; i++) rd_chk("R5 stored result", i + 1, exp_res[i]);
    repeat (3) tick();
    chk("R5 no request after one pass", int'(pend), 0);
    // R8 DMA read of a result clears the flag
    dma_ack = 1; bus_rd = 1; bus_addr = 4'd2; tick(); bus_rd = 0; dma_ack = 0;
    chk("R8 irq after dma read", int'(irq), 0);
    rd_chk("R8 flag cleared by dma", 0, 'h400B);

    // R6 scan mode over channels 0..1, interrupt disabled
    pend = 0;
    wr(0, 16'h2011);
    for (int i = 0; i < 2; i++) begin serve(1, ch); chk("R6 pass 1 order", ch, i); end
    tick();
    rd_chk("R6 flag set, run kept", 0, 'hA011);
    for (int i = 0; i < 2; i++) begin serve(1, ch); chk("R6 wrap to channel 0", ch, i); end
    // R13 configuration frozen during a run
    wr(0, 16'hA007);
    rd_chk("R13 mode and channel unchanged", 0, 'hA011);
    // R9 pass end and qualifying clear in the same cycle
    serve(1, ch);
    chk("R6 pass 3 start", ch, 0);
    wait_req(ch);
    tick();
    mk_data(ch, d);
    conv_done = 1; conv_data = 12'(d); bus_wr = 1; bus_addr = 4'd0; bus_wdata = 16'h0000;
    tick();
    conv_done = 0; bus_wr = 0;
    exp_res[ch] = d;
    rd_chk("R9 set wins over clear", 0, 'h8011);
    rd_chk("R9 last result stored", 2, exp_res[1]);

    // R11 abort by software
    rd(0, old);
    wr(0, 16'h0011);
    rd_chk("R7 flag cleared", 0, 'h0011);
    pend = 0;
    wr(0, 16'h200A);
    serve(1, ch);
    wait_req(ch);
    chk("R11 second channel requested", ch, 1);
    rd(2, old);
    wr(0, 16'h000A);
    pend = 0;
    repeat (2) tick();
    conv_done = 1; conv_data = 12'hABC; tick(); conv_done = 0;
    rd_chk("R11 abandoned result unchanged", 2, old);
    rd_chk("R11 idle with no flag", 0, 'h000A);
    for (int i = 0; i < 4; i++) begin tick(); chk("R11 no request after abort", int'(conv_req), 0); end

    // R12 standby
    pend = 0;
    wr(0, 16'h200A);
    serve(1, ch);
    wait_req(ch);
    standby = 1; tick(); standby = 0;
    rd_chk("R12 standby cleared run", 0, 'h000A);
    conv_done = 1; conv_data = 12'h5A5; tick(); conv_done = 0;
    rd_chk("R12 late done ignored", 2, exp_res[1]);
    pend = 0;
    standby = 1; wr(0, 16'h200A); standby = 0;
    rd_chk("R12 start ignored in standby", 0, 'h000A);
    repeat (4) tick();
    chk("R12 no request after blocked start", int'(pend), 0);

    // R4 mode 11 behaves as single
    pend = 0;
    wr(0, 16'h201C);
    serve(1, ch);
    chk("R4 mode 11 single channel", ch, 4);
    tick();
    rd_chk("R4 mode 11 completion", 0, 'h801C);
    rd_chk("R4 mode 11 result", 5, exp_res[4]);

    repeat (3) tick();
    live = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule